// File: doc/BRIEF.md
# Shared Interrupt Controller

This block collects edge-signalled interrupt requests from a set of shared peripheral lines and delivers them to a single processor core over one IRQ wire. It has two halves behind a simple word-addressed register bus. The distributor half holds a global forward enable, per-ID enable bits, per-ID pending bits and a per-ID routing bit. The CPU-interface half holds a signalling enable, a priority threshold, an acknowledge register and an end-of-interrupt register.

There are 64 interrupt IDs. Shared peripheral line k feeds ID k+32, so line 25 is ID 57. IDs below 32 have enable and routing storage but no request source. Every ID has the fixed priority 0, which is the highest. Software sets up the enables and the routing and opens the threshold. When IRQ rises it reads the acknowledge register to claim the lowest-numbered eligible ID. It then writes that ID to the end-of-interrupt register once handling is done. Only one interrupt can be active at a time.

Register reads are registered: data appears on `regRdData` in the cycle after `regRdEn` is sampled. Writes take effect at the clock edge that samples `regWrEn`.

Top module: `shared_irq_ctrl`

## Requirements
- R1: A rising edge on `spiIn[k]`, judged against the value sampled one cycle earlier, sets the pending bit of ID k+32 at the same clock edge. Pending bits read back at word addresses 8 (IDs 0–31) and 9 (IDs 32–63), one bit per ID at position ID%32.
- R2: Writing word address 4 + ID/32 sets the enable of every ID whose bit (ID%32) in the write data is 1. Zero bits leave their enables unchanged. Reading the same address returns the enables.
- R3: Writing word address 8 + ID/32 clears the pending bit of every ID whose bit is 1 in the write data. Zero bits leave their pending bits unchanged.
- R4: Routing for ID i sits at word address 16 + i/4, byte i%4, and only bit 0 of that byte is stored (1 = routed to the core). On read the other bits of every byte return 0.
- R5: Bit 0 of word address 0 is the distributor enable. While it is 0, IRQ stays low and an acknowledge read returns 1023.
- R6: Bit 0 of word address 32 is the CPU-interface enable. While it is 0, IRQ stays low and an acknowledge read returns 1023.
- R7: Word address 33 is an 8-bit priority threshold, reset to 0 and readable. An ID passes only when its priority (0) is below the threshold, so a threshold of 0 blocks everything and 0xFF passes everything.
- R8: An ID is eligible when it is pending, enabled and routed, and the two enables and the threshold let it through. A read of word address 34 while IRQ is high returns the lowest-numbered eligible ID in bits [9:0], with the upper bits 0. The same read clears that ID's pending bit and makes it the active interrupt.
- R9: A read of word address 34 while IRQ is low, including while an interrupt is active, returns 1023 and changes no pending or active state.
- R10: IRQ is high exactly when some ID is eligible, the CPU-interface enable is 1, and no interrupt is active.
- R11: Writing word address 35 with an ID in bits [9:0] that equals the active ID ends the active interrupt. Any other value leaves the active interrupt in place.
- R12: After reset all enables, pending bits, routing bits, the two control enables and the threshold are 0, no interrupt is active, and IRQ is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| spiIn | input | 32 | Shared peripheral request lines, synchronous to clk |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 6 | Word address |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Registered read data |
| irq | output | 1 | Interrupt request to the core |

## Verification
Pending bits, enables, routing and the active state change at the edge that samples the input line or the register strobe. IRQ is a combinational function of that state, so it is due in the same cycle right after that edge. Read data, acknowledge results included, is due one edge after the read strobe. The bench drives every stimulus on a falling edge and updates its model for the single rising edge that follows. It then compares IRQ and read data on the next falling edge, where both of these results have already settled.

// File: rtl/shared_irq_pkg.sv
package shared_irq_pkg;
  localparam int REG_W        = 32;
  localparam int IDX_W        = 4;
  localparam int ADDR_DCTRL   = 0;
  localparam int ADDR_SETEN   = 4;
  localparam int ADDR_CLRPEND = 8;
  localparam int ADDR_TARGET  = 16;
  localparam int ADDR_CCTRL   = 32;
  localparam int ADDR_PMR     = 33;
  localparam int ADDR_ACK     = 34;
  localparam int ADDR_EOI     = 35;
  localparam logic [9:0] NO_IRQ_ID = 10'd1023;

  typedef enum logic [2:0] {
    RD_ZERO, RD_DCTRL, RD_SETEN, RD_PEND, RD_TARGET, RD_CCTRL, RD_PMR, RD_ACK
  } rdSel_e;

  typedef struct packed {
    logic distCtrlWr;
    logic setEnWr;
    logic clrPendWr;
    logic targetWr;
    logic cpuCtrlWr;
    logic pmrWr;
    logic eoiWr;
    logic ackRd;
    logic rdEn;
    rdSel_e rdSel;
    logic [IDX_W-1:0] idx;
  } strobes_t;
endpackage

// File: rtl/shared_irq_decode.sv
module shared_irq_decode
  import shared_irq_pkg::*;
#(
  parameter int NUM_IDS = 64,
  parameter int ADDR_W  = 6
) (
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  output strobes_t          strb
);
  localparam int EN_REGS  = NUM_IDS / 32;
  localparam int TGT_REGS = NUM_IDS / 4;

  logic inSetEn, inClrPend, inTarget;

  assign inSetEn   = (regAddr >= ADDR_W'(ADDR_SETEN))   && (regAddr < ADDR_W'(ADDR_SETEN + EN_REGS));
  assign inClrPend = (regAddr >= ADDR_W'(ADDR_CLRPEND)) && (regAddr < ADDR_W'(ADDR_CLRPEND + EN_REGS));
  assign inTarget  = (regAddr >= ADDR_W'(ADDR_TARGET))  && (regAddr < ADDR_W'(ADDR_TARGET + TGT_REGS));

  always_comb begin
    strb       = '0;
    strb.rdEn  = regRdEn;
    strb.rdSel = RD_ZERO;
    if (regAddr == ADDR_W'(ADDR_DCTRL)) begin
      strb.distCtrlWr = regWrEn;
      strb.rdSel      = RD_DCTRL;
    end else if (inSetEn) begin
      strb.setEnWr = regWrEn;
      strb.rdSel   = RD_SETEN;
      strb.idx     = IDX_W'(regAddr - ADDR_W'(ADDR_SETEN));
    end else if (inClrPend) begin
      strb.clrPendWr = regWrEn;
      strb.rdSel     = RD_PEND;
      strb.idx       = IDX_W'(regAddr - ADDR_W'(ADDR_CLRPEND));
    end else if (inTarget) begin
      strb.targetWr = regWrEn;
      strb.rdSel    = RD_TARGET;
      strb.idx      = IDX_W'(regAddr - ADDR_W'(ADDR_TARGET));
    end else if (regAddr == ADDR_W'(ADDR_CCTRL)) begin
      strb.cpuCtrlWr = regWrEn;
      strb.rdSel     = RD_CCTRL;
    end else if (regAddr == ADDR_W'(ADDR_PMR)) begin
      strb.pmrWr = regWrEn;
      strb.rdSel = RD_PMR;
    end else if (regAddr == ADDR_W'(ADDR_ACK)) begin
      strb.ackRd = regRdEn;
      strb.rdSel = RD_ACK;
    end else if (regAddr == ADDR_W'(ADDR_EOI)) begin
      strb.eoiWr = regWrEn;
    end
  end
endmodule

// File: rtl/shared_irq_datapath.sv
module shared_irq_datapath
  import shared_irq_pkg::*;
#(
  parameter int NUM_IDS  = 64,
  parameter int NUM_SPI  = 32,
  parameter int SPI_BASE = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobes_t           strb,
  input  logic [REG_W-1:0]   wrData,
  input  logic [NUM_SPI-1:0] spiIn,
  output logic [REG_W-1:0]   rdData,
  output logic               irq
);
  localparam int EN_REGS  = NUM_IDS / 32;
  localparam int TGT_REGS = NUM_IDS / 4;
  localparam int ID_W     = $clog2(NUM_IDS);
  localparam logic [7:0] FIXED_PRIO = 8'd0;

  logic               distEn, cpuEn, activeValid;
  logic [7:0]         pmr;
  logic [9:0]         activeId;
  logic [NUM_IDS-1:0] enQ, pendQ, tgtQ;
  logic [NUM_SPI-1:0] spiPrev;
  logic [REG_W-1:0]   rdDataQ, rdMux;

  logic [NUM_IDS-1:0] elig, setMask, clrMask, ackMask, riseMask, pendNext;
  logic [ID_W-1:0]    winId;
  logic               found, irqD, ackTake;

  // Eligibility and lowest-ID winner
  assign elig = pendQ & enQ & tgtQ & {NUM_IDS{distEn && (FIXED_PRIO < pmr)}};

  always_comb begin
    winId = '0;
    found = 1'b0;
    for (int i = NUM_IDS - 1; i >= 0; i--) begin
      if (elig[i]) begin
        winId = ID_W'(i);
        found = 1'b1;
      end
    end
  end

  assign irqD    = cpuEn && found && !activeValid;
  assign ackTake = strb.ackRd && irqD;

  // Pending next-state: edge sets win over clears
  always_comb begin
    setMask  = '0;
    clrMask  = '0;
    ackMask  = '0;
    riseMask = '0;
    for (int w = 0; w < EN_REGS; w++) begin
      if (strb.setEnWr && (int'(strb.idx) == w))   setMask[w*32 +: 32] = wrData;
      if (strb.clrPendWr && (int'(strb.idx) == w)) clrMask[w*32 +: 32] = wrData;
    end
    if (ackTake) ackMask[winId] = 1'b1;
    riseMask[SPI_BASE +: NUM_SPI] = spiIn & ~spiPrev;
    pendNext = (pendQ & ~clrMask & ~ackMask) | riseMask;
  end

  // Read mux
  always_comb begin
    rdMux = '0;
    unique case (strb.rdSel)
      RD_DCTRL: rdMux[0] = distEn;
      RD_CCTRL: rdMux[0] = cpuEn;
      RD_PMR:   rdMux[7:0] = pmr;
      RD_ACK:   rdMux = irqD ? REG_W'(winId) : REG_W'(NO_IRQ_ID);
      RD_SETEN, RD_PEND: begin
        for (int w = 0; w < EN_REGS; w++)
          if (int'(strb.idx) == w)
            rdMux = (strb.rdSel == RD_SETEN) ? enQ[w*32 +: 32] : pendQ[w*32 +: 32];
      end
      RD_TARGET: begin
        for (int r = 0; r < TGT_REGS; r++)
          if (int'(strb.idx) == r)
            for (int b = 0; b < 4; b++) rdMux[8*b] = tgtQ[r*4 + b];
      end
      default: rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      distEn      <= 1'b0;
      cpuEn       <= 1'b0;
      pmr         <= '0;
      enQ         <= '0;
      pendQ       <= '0;
      tgtQ        <= '0;
      spiPrev     <= '0;
      activeValid <= 1'b0;
      activeId    <= NO_IRQ_ID;
      rdDataQ     <= '0;
    end else begin
      spiPrev <= spiIn;
      pendQ   <= pendNext;
      enQ     <= enQ | setMask;
      if (strb.distCtrlWr) distEn <= wrData[0];
      if (strb.cpuCtrlWr)  cpuEn  <= wrData[0];
      if (strb.pmrWr)      pmr    <= wrData[7:0];
      for (int r = 0; r < TGT_REGS; r++)
        if (strb.targetWr && (int'(strb.idx) == r))
          for (int b = 0; b < 4; b++) tgtQ[r*4 + b] <= wrData[8*b];
      if (ackTake) begin
        activeValid <= 1'b1;
        activeId    <= 10'(winId);
      end else if (strb.eoiWr && activeValid && (wrData[9:0] == activeId)) begin
        activeValid <= 1'b0;
      end
      if (strb.rdEn) rdDataQ <= rdMux;
    end
  end

  assign rdData = rdDataQ;
  assign irq    = irqD;

  // R1: an edge on the first shared line reaches its pending bit
  assert_edge_sets_pending_R1: assert property (@(posedge clk) disable iff (!rstN)
    (spiIn[0] && !spiPrev[0]) |=> pendQ[SPI_BASE]);

  // R8: a granted acknowledge returns the winner and makes it active
  assert_ack_grants_winner_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ackRd && irq) |=> (activeValid && (rdData == REG_W'($past(winId)))));

  // R9: an acknowledge with IRQ low returns 1023 and keeps the active state
  assert_idle_ack_spurious_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ackRd && !irq) |=> ((rdData == REG_W'(NO_IRQ_ID)) && $stable(activeValid)));

  // R11: an end-of-interrupt with a foreign ID leaves the active one alone
  assert_wrong_eoi_ignored_R11: assert property (@(posedge clk) disable iff (!rstN)
    (strb.eoiWr && activeValid && (wrData[9:0] != activeId)) |=> activeValid);
endmodule

// File: rtl/shared_irq_ctrl.sv
module shared_irq_ctrl
  import shared_irq_pkg::*;
#(
  parameter int NUM_IDS  = 64,
  parameter int NUM_SPI  = 32,
  parameter int SPI_BASE = 32,
  parameter int ADDR_W   = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SPI-1:0] spiIn,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [REG_W-1:0]   regWrData,
  output logic [REG_W-1:0]   regRdData,
  output logic               irq
);
  strobes_t strb;

  shared_irq_decode #(.NUM_IDS(NUM_IDS), .ADDR_W(ADDR_W)) decode_i (
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .regAddr (regAddr),
    .strb    (strb)
  );

  shared_irq_datapath #(.NUM_IDS(NUM_IDS), .NUM_SPI(NUM_SPI), .SPI_BASE(SPI_BASE)) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrData (regWrData),
    .spiIn  (spiIn),
    .rdData (regRdData),
    .irq    (irq)
  );
endmodule

// File: tb/shared_irq_ctrl_tb_top.sv
module shared_irq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] A_DCTRL = 6'd0, A_SETEN = 6'd4, A_CLRP = 6'd8, A_TGT = 6'd16,
                         A_CCTRL = 6'd32, A_PMR = 6'd33, A_ACK = 6'd34, A_EOI = 6'd35;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] spiIn = '0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [5:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        irq;

  int compared = 0;
  int mismatched = 0;

  // Reference model state
  logic [63:0] mEn = '0, mPend = '0, mTgt = '0;
  logic        mDist = 0, mCpu = 0, mAct = 0;
  logic [7:0]  mPmr = '0;
  logic [9:0]  mActId = '0;
  logic [31:0] mPrev = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shared_irq_ctrl dut_i (
    .clk(clk), .rstN(rstN), .spiIn(spiIn), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData), .irq(irq)
  );

  function automatic logic [63:0] mElig();
    return mPend & mEn & mTgt & {64{mDist && (mPmr != 8'd0)}};
  endfunction

  function automatic logic mIrq();
    return mCpu && (|mElig()) && !mAct;
  endfunction

  function automatic logic [9:0] mWinner();
    logic [63:0] e = mElig();
    for (int i = 0; i < 64; i++) if (e[i]) return 10'(i);
    return 10'd1023;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
    if (a == A_DCTRL) mDist = d[0];
    else if (a == A_CCTRL) mCpu = d[0];
    else if (a == A_PMR) mPmr = d[7:0];
    else if (a >= A_SETEN && a < A_SETEN + 2) mEn[(a - A_SETEN)*32 +: 32] |= d;
    else if (a >= A_CLRP && a < A_CLRP + 2) mPend[(a - A_CLRP)*32 +: 32] &= ~d;
    else if (a >= A_TGT && a < A_TGT + 16)
      for (int b = 0; b < 4; b++) mTgt[(a - A_TGT)*4 + b] = d[8*b];
    else if (a == A_EOI && mAct && d[9:0] == mActId) mAct = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    @(negedge clk);
    regRdEn = 1'b0;
    d = regRdData;
  endtask

  task automatic setSpi(input logic [31:0] v);
    @(negedge clk);
    spiIn = v;
    @(negedge clk);
    mPend[63:32] |= v & ~mPrev;
    mPrev = v;
  endtask

  task automatic pulse(input logic [31:0] v);
    setSpi(v);
    setSpi('0);
  endtask

  task automatic ackCheck(input string req);
    logic [31:0] got, exp;
    logic wantIrq = mIrq();
    exp = wantIrq ? 32'(mWinner()) : 32'd1023;
    rd(A_ACK, got);
    if (wantIrq) begin
      mPend[exp[5:0]] = 1'b0;
      mAct = 1'b1;
      mActId = exp[9:0];
    end
    chk(req, got, exp);
  endtask

  task automatic irqCheck(input string req);
    chk(req, 32'(irq), 32'(mIrq()));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R12: reset state
    chk("R12 irq", 32'(irq), 32'd0);
    rd(A_PMR, d);   chk("R12 pmr", d, 32'd0);
    rd(A_SETEN+1, d); chk("R12 enables", d, 32'd0);
    rd(A_TGT+14, d); chk("R12 routing", d, 32'd0);
    rd(A_DCTRL, d); chk("R12 dist ctrl", d, 32'd0);

    // Bring-up for line 25 -> ID 57
    wr(A_SETEN+1, 32'h1 << 25);
    wr(A_TGT+14, 32'h1 << 8);
    wr(A_PMR, 32'hFF);
    wr(A_CCTRL, 32'h1);
    pulse(32'h1 << 25);
    rd(A_CLRP+1, d); chk("R1 pending ID57", d, 32'h1 << 25);
    irqCheck("R5 dist off blocks irq");
    ackCheck("R5 dist off ack 1023");
    wr(A_DCTRL, 32'h1);
    chk("R10 irq high", 32'(irq), 32'd1);
    ackCheck("R8 ack ID57");
    chk("R8 ack value", 32'(mActId), 32'd57);
    irqCheck("R10 irq low while active");
    rd(A_CLRP+1, d); chk("R8 pending cleared", d, 32'd0);

    // R9 / R11: ack while active, foreign EOI
    pulse(32'h1 << 25);
    ackCheck("R9 ack while active");
    wr(A_EOI, 32'd56);
    chk("R11 wrong eoi keeps active", 32'(irq), 32'd0);
    wr(A_EOI, 32'd57);
    chk("R11 eoi releases", 32'(irq), 32'd1);
    ackCheck("R8 second ack");
    wr(A_EOI, 32'd57);

    // R2 / R8: tie resolution among lines 3 and 10
    wr(A_SETEN+1, (32'h1 << 3) | (32'h1 << 10));
    rd(A_SETEN+1, d); chk("R2 enable readback", d, (32'h1 << 3) | (32'h1 << 10) | (32'h1 << 25));
    wr(A_SETEN+1, 32'h0);
    rd(A_SETEN+1, d); chk("R2 zero write no effect", d, (32'h1 << 3) | (32'h1 << 10) | (32'h1 << 25));
    wr(A_TGT+8, 32'h0000_0001);   // ID 32..35 -> byte 3 for ID 35
    wr(A_TGT+8, 32'h0100_0000);
    wr(A_TGT+10, 32'h0000_0100);  // ID 41? byte1 = ID 41; ID 42 is byte 2
    wr(A_TGT+10, 32'h0001_0000);
    pulse((32'h1 << 3) | (32'h1 << 10));
    ackCheck("R8 lowest ID first");
    wr(A_EOI, {22'd0, mActId});
    ackCheck("R8 next ID");
    wr(A_EOI, {22'd0, mActId});

    // R4: only bit 0 of each routing byte is kept
    wr(A_TGT+3, 32'hFFFF_FFFE);
    rd(A_TGT+3, d); chk("R4 routing readback", d, 32'h0101_0100);

    // R3: clear pending
    pulse(32'h1 << 25);
    wr(A_CLRP+1, 32'h0);
    rd(A_CLRP+1, d); chk("R3 zero clear no effect", d, 32'h1 << 25);
    wr(A_CLRP+1, 32'h1 << 25);
    rd(A_CLRP+1, d); chk("R3 pending cleared", d, 32'd0);

    // R7 / R6 gating
    pulse(32'h1 << 25);
    wr(A_PMR, 32'h0);
    irqCheck("R7 mask 0 blocks");
    ackCheck("R7 mask 0 ack 1023");
    rd(A_PMR, d); chk("R7 pmr readback", d, 32'd0);
    wr(A_PMR, 32'h1);
    irqCheck("R7 mask 1 passes");
    wr(A_CCTRL, 32'h0);
    irqCheck("R6 cpu off blocks");
    ackCheck("R6 cpu off ack 1023");
    wr(A_CCTRL, 32'h1);
    ackCheck("R8 ack after gating");
    wr(A_EOI, {22'd0, mActId});

    // Constrained random mix
    for (int n = 0; n < 400; n++) begin
      int op = $urandom_range(0, 8);
      case (op)
        0, 1: pulse($urandom & $urandom & $urandom);
        2: wr(A_SETEN + 6'($urandom_range(0, 1)), $urandom & $urandom);
        3: wr(A_CLRP + 6'($urandom_range(0, 1)), $urandom & $urandom);
        4: wr(A_TGT + 6'($urandom_range(0, 15)), $urandom);
        5: ackCheck("R8 random ack");
        6: wr(A_EOI, ($urandom_range(0, 3) != 0) ? {22'd0, mActId} : 32'($urandom_range(0, 1023)));
        7: begin
          int s = $urandom_range(0, 9);
          if (s == 0) wr(A_PMR, 32'($urandom_range(0, 255)));
          else if (s == 1) wr(A_DCTRL, 32'($urandom_range(0, 3) != 0));
          else if (s == 2) wr(A_CCTRL, 32'($urandom_range(0, 3) != 0));
          else wr(A_PMR, 32'hFF);
        end
        default: begin
          rd(A_CLRP+1, d); chk("R1 random pending", d, mPend[63:32]);
        end
      endcase
      irqCheck("R10 random irq");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule